// File: doc/BRIEF.md
# Reset Source Status Register

This block keeps a record of which event brought about the latest system reset. A separate one-bit flag records whether a break interrupt ended a low-power wait. Each reset source arrives as a single-cycle pulse: power-on, external reset pin, watchdog timeout, illegal opcode, illegal address and low supply voltage. A further pulse reports a break that ended a wait.

Firmware reads the flags through a small byte-wide read/write bus. The cause register sits at offset 1 and the break register at offset 0.

- A read of the cause register hands back the flags and then empties the register, so each cause is reported once.
- The power-on pulse is the only event that initialises the storage. It leaves just the power-on flag set. Every other source adds its own flag to whatever is already held.
- The break flag is cleared by writing 0 to it.

Top module: `rst_cause_reg`

## Requirements
- R1: Cause register bit positions: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 1 low voltage. Bits 2 and 0 of the cause register, and every break register bit except bit 1, always read 0.
- R2: A power-on pulse sets the cause register to 0x80 and the break register to 0x00 on the following cycle, whatever the contents were before.
- R3: Each non-power-on source pulse sets only its own bit on the following cycle and leaves all other cause bits unchanged, so flags accumulate.
- R4: A read of offset 1 returns the current cause contents in the same cycle. The register holds 0x00 from the next cycle.
- R5: When a source pulse coincides with a read of offset 1, the read returns the old contents. Afterwards the register holds only the newly flagged bit or bits.
- R6: A break-exited-wait pulse sets break register bit 1 on the following cycle.
- R7: Writing offset 0 with data bit 1 equal to 0 clears the break flag. Writing it with bit 1 equal to 1 has no effect. A break pulse in the same cycle as a clearing write leaves the flag set.
- R8: Writes to offset 1 do not change the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_evt_i | input | 1 | Power-on pulse; also initialises all storage |
| pin_evt_i | input | 1 | External reset pin pulse |
| wdog_evt_i | input | 1 | Watchdog timeout reset pulse |
| ilop_evt_i | input | 1 | Illegal opcode reset pulse |
| ilad_evt_i | input | 1 | Illegal address reset pulse |
| lvi_evt_i | input | 1 | Low-voltage reset pulse |
| brk_wait_evt_i | input | 1 | Break interrupt ended wait mode |
| addr_i | input | ADDR_W | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |

## Verification
The bench aims at a source pulse that lands in the same cycle as a clearing read. A design that lets the clear win would lose that cause, and one that updates before the read would report it early. It also checks that sources accumulate after an earlier power-on flag, which a design that treats every reset as a full clear would wipe. On the break register it checks three cases:
- A write of 1, which a design decoding the wrong data polarity would turn into a clear.
- A write of 0 with the reserved bits set to 1, which a design could mistake for a write of 1.
- A set that coincides with a clear, where the set must win.

// File: rtl/rsr_pkg.sv
`timescale 1ns/1ps
package rsr_pkg;
    localparam int REG_W    = 8;
    localparam int NSRC     = 5;
    localparam int POR_BIT  = 7;
    localparam int BRK_BIT  = 1;
    // source index: 0 pin, 1 watchdog, 2 illegal opcode, 3 illegal address, 4 low voltage
    localparam int SRC_POS [NSRC] = '{6, 5, 4, 3, 1};

    typedef struct packed {
        logic [REG_W-1:0] flags;
    } cause_state_t;

    typedef struct packed {
        logic brk;
    } brk_state_t;
endpackage

// File: rtl/rsr_bus_decode.sv
`timescale 1ns/1ps
module rsr_bus_decode #(
    parameter int ADDR_W   = 8,
    parameter int STAT_OFS = 1,
    parameter int BRK_OFS  = 0
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     rd_i,
    input  logic                     wr_i,
    input  logic [rsr_pkg::REG_W-1:0] stat_i,
    input  logic                     brk_i,
    output logic                     stat_rd_o,
    output logic                     brk_wr_o,
    output logic [rsr_pkg::REG_W-1:0] rdata_o
);
    import rsr_pkg::*;

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] BRK_A  = ADDR_W'(BRK_OFS);

    logic sel_stat, sel_brk;

    always_comb begin
        sel_stat  = (addr_i == STAT_A);
        sel_brk   = (addr_i == BRK_A);
        stat_rd_o = rd_i & sel_stat;
        brk_wr_o  = wr_i & sel_brk;
        rdata_o   = '0;
        if (sel_stat) begin
            rdata_o = stat_i;
        end else if (sel_brk) begin
            rdata_o[BRK_BIT] = brk_i;
        end
    end
endmodule

// File: rtl/rsr_cause_flags.sv
`timescale 1ns/1ps
module rsr_cause_flags (
    input  logic                      clk,
    input  logic                      por_i,
    input  logic [rsr_pkg::NSRC-1:0]  src_i,
    input  logic                      clr_i,
    output logic [rsr_pkg::REG_W-1:0] flags_o
);
    import rsr_pkg::*;

    cause_state_t st_d, st_q;
    logic [REG_W-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < NSRC; i++) begin
            set_mask[SRC_POS[i]] = src_i[i];
        end
        st_d = st_q;
        if (por_i) begin
            st_d.flags          = '0;
            st_d.flags[POR_BIT] = 1'b1;
        end else if (clr_i) begin
            st_d.flags = set_mask;
        end else begin
            st_d.flags = st_q.flags | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    // R3
    sticky_flags_chk: assert property (@(posedge clk) disable iff (por_i)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (por_i)
        (clr_i && src_i == '0) |=> (flags_o == '0));

    // R5
    collide_keeps_chk: assert property (@(posedge clk) disable iff (por_i)
        (clr_i && src_i != '0) |=> (flags_o != '0));
endmodule

// File: rtl/rsr_break_flag.sv
`timescale 1ns/1ps
module rsr_break_flag (
    input  logic clk,
    input  logic por_i,
    input  logic set_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic brk_o
);
    import rsr_pkg::*;

    brk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d.brk = 1'b0;
        end else if (set_i) begin
            st_d.brk = 1'b1;
        end else if (wr_i && !wbit_i) begin
            st_d.brk = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign brk_o = st_q.brk;

    // R6
    brk_set_chk: assert property (@(posedge clk) disable iff (por_i)
        set_i |=> brk_o);

    // R7
    brk_write_one_chk: assert property (@(posedge clk) disable iff (por_i)
        (wr_i && wbit_i && !set_i) |=> $stable(brk_o));
endmodule

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg #(
    parameter int ADDR_W   = 8,
    parameter int STAT_OFS = 1,
    parameter int BRK_OFS  = 0
) (
    input  logic              clk,
    input  logic              por_evt_i,
    input  logic              pin_evt_i,
    input  logic              wdog_evt_i,
    input  logic              ilop_evt_i,
    input  logic              ilad_evt_i,
    input  logic              lvi_evt_i,
    input  logic              brk_wait_evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);
    import rsr_pkg::*;

    logic [NSRC-1:0]  src_vec;
    logic [REG_W-1:0] stat_q;
    logic             brk_q;
    logic             stat_rd;
    logic             brk_wr;

    assign src_vec = {lvi_evt_i, ilad_evt_i, ilop_evt_i, wdog_evt_i, pin_evt_i};

    rsr_bus_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .BRK_OFS  (BRK_OFS)
    ) u_dec (
        .addr_i    (addr_i),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .stat_i    (stat_q),
        .brk_i     (brk_q),
        .stat_rd_o (stat_rd),
        .brk_wr_o  (brk_wr),
        .rdata_o   (rdata_o)
    );

    rsr_cause_flags u_cause (
        .clk     (clk),
        .por_i   (por_evt_i),
        .src_i   (src_vec),
        .clr_i   (stat_rd),
        .flags_o (stat_q)
    );

    rsr_break_flag u_brk (
        .clk    (clk),
        .por_i  (por_evt_i),
        .set_i  (brk_wait_evt_i),
        .wr_i   (brk_wr),
        .wbit_i (wdata_i[BRK_BIT]),
        .brk_o  (brk_q)
    );

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (por_evt_i)
        (addr_i == ADDR_W'(STAT_OFS)) |-> (rdata_o[2] == 1'b0 && rdata_o[0] == 1'b0));
endmodule

// File: tb/sim_rst_cause_reg.sv
`timescale 1ns/1ps
module sim_rst_cause_reg;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic [6:0] ev = '0;   // 0 pin,1 wdog,2 ilop,3 ilad,4 lvi,5 brk
    logic [7:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    rst_cause_reg u0 (
        .clk(clk), .por_evt_i(por), .pin_evt_i(ev[0]), .wdog_evt_i(ev[1]),
        .ilop_evt_i(ev[2]), .ilad_evt_i(ev[3]), .lvi_evt_i(ev[4]),
        .brk_wait_evt_i(ev[5]), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // one bus cycle from a falling edge; if chk, sample rdata mid-cycle
    task automatic cyc(input logic p, input logic [6:0] e, input logic [7:0] a,
                       input logic r, input logic w, input logic [7:0] d,
                       input bit chk, input logic [7:0] exp, input string tag);
        por = p; ev = e; addr = a; rd = r; wr = w; wdata = d;
        #1;
        if (chk) check(rdata, exp, tag);
        @(negedge clk);
        por = 0; ev = '0; rd = 0; wr = 0; wdata = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cyc(0, '0, a, 1, 0, 8'h00, 1, exp, tag);
    endtask

    task automatic pulse(input logic [6:0] e);
        cyc(0, e, 8'h00, 0, 0, 8'h00, 0, 8'h00, "");
    endtask

    task automatic t_power_on;
        pulse(7'h0B);
        cyc(1, '0, 8'h00, 0, 0, 8'h00, 0, 8'h00, "");
        rd_chk(8'h01, 8'h80, "R2 cause after power-on");
        rd_chk(8'h00, 8'h00, "R2 break after power-on");
        rd_chk(8'h01, 8'h00, "R4 cleared after read");
    endtask

    task automatic t_singles;
        logic [7:0] pos [5] = '{8'h40, 8'h20, 8'h10, 8'h08, 8'h02};
        for (int i = 0; i < 5; i++) begin
            pulse(7'(1 << i));
            rd_chk(8'h01, pos[i], "R1 R3 single source bit");
            rd_chk(8'h01, 8'h00, "R4 read clears single");
        end
    endtask

    task automatic t_accumulate;
        cyc(1, '0, 8'h00, 0, 0, 8'h00, 0, 8'h00, "");
        pulse(7'h04);
        rd_chk(8'h01, 8'h90, "R3 ilop keeps power-on flag");
        pulse(7'h01); pulse(7'h02); pulse(7'h10);
        rd_chk(8'h01, 8'h62, "R3 pin+wdog+lvi accumulate");
        cyc(1, 7'h10, 8'h00, 0, 0, 8'h00, 0, 8'h00, "");
        rd_chk(8'h01, 8'h80, "R2 power-on overrides sources");
    endtask

    task automatic t_collide;
        pulse(7'h01);
        cyc(0, 7'h08, 8'h01, 1, 0, 8'h00, 1, 8'h40, "R5 read returns old value");
        rd_chk(8'h01, 8'h08, "R5 new flag kept");
        rd_chk(8'h01, 8'h00, "R4 empty after read");
    endtask

    task automatic t_write_ignored;
        pulse(7'h02);
        cyc(0, '0, 8'h01, 0, 1, 8'hFF, 0, 8'h00, "");
        rd_chk(8'h01, 8'h20, "R8 write of FF ignored");
        cyc(0, '0, 8'h01, 0, 1, 8'h00, 0, 8'h00, "");
        rd_chk(8'h01, 8'h00, "R8 read still clears");
    endtask

    task automatic t_break;
        pulse(7'h20);
        rd_chk(8'h00, 8'h02, "R6 break flag set");
        rd_chk(8'h00, 8'h02, "R6 break read does not clear");
        cyc(0, '0, 8'h00, 0, 1, 8'h02, 0, 8'h00, "");
        rd_chk(8'h00, 8'h02, "R7 writing 1 no effect");
        cyc(0, '0, 8'h00, 0, 1, 8'hFD, 0, 8'h00, "");
        rd_chk(8'h00, 8'h00, "R7 R1 writing 0 clears, reserved zero");
        cyc(0, 7'h20, 8'h00, 0, 1, 8'h00, 0, 8'h00, "");
        rd_chk(8'h00, 8'h02, "R7 set wins over clear");
        rd_chk(8'h01, 8'h00, "R1 break event leaves cause empty");
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(1, '0, 8'h00, 0, 0, 8'h00, 0, 8'h00, "");
        t_power_on();
        t_singles();
        t_accumulate();
        t_collide();
        t_write_ignored();
        t_break();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule